// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

A bank of event counters that a memory controller uses to measure its own traffic. Counter 0 is a free-running cycle counter. Counters 1 and up each count the one-cycle strobes of a single event, picked by an 8-bit code out of an event strobe vector. Software sees each counter through a control word and a read-only count word on a simple single-cycle register bus.

The cycle counter is the master of the bank. While it is disabled, or after it has reached its top value, no counter advances. When it tops out it raises a level interrupt, so that software can read and restart every counter before any event counter can fill up. An event counter that fills up on its own stops and flags this in its control word, but raises no interrupt. A clear loads a software-chosen byte into the middle of the count. This lets the cycle counter be biased to top out early. The two kinds of counter are cleared by different write sequences.

Top module: `ddr_perf_bank`

## Requirements
- R1: After reset every control word and every count reads 0 and `irq_o` is low.
- R2: The control word of counter i sits at byte offset 4*i and its count at 0x20 + 4*i. Any other offset reads 0. Writes to count offsets have no effect. Counts narrower than 32 bits read zero-extended.
- R3: Control word fields: bit 0 is the overflow flag, which is read-only and ignores writes. Bit 1 is clear, bit 2 is enable, bits 23:16 are the preload byte and bits 31:24 the event code. All other bits read 0. The code field of counter 0 always reads 0.
- R4: The cycle counter adds one on every clock while it is enabled and not overflowed.
- R5: The cycle counter clears only on a write that takes its clear bit from 0 to 1. Writing 1 over a stored 1 does not clear it.
- R6: An event counter clears on any write with the clear bit at 0. Its clear bit then reads 1.
- R7: A clear sets the count to the written preload byte placed at bits [CNT_W-9:CNT_W-16] (23:16 for 32 bits), with all other bits 0. It drops the overflow flag in the same clock. An event strobe in the clear cycle is not counted.
- R8: Event counter i adds one per clock in which `event_i[code]` is high, its own enable is set, the cycle counter is enabled and the cycle counter is not overflowed. Code 0 and codes at or above N_EVT count nothing.
- R9: A cycle counter step at the all-ones value sets its overflow flag and leaves the count at all-ones. From the next clock every counter holds its value until software acts.
- R10: An event counter step at all-ones sets that counter's overflow flag, holds it at all-ones and stops it. The interrupt is not raised, and the other counters go on.
- R11: `irq_o` is high exactly while the cycle counter's overflow flag and enable are both set. It drops when that counter is disabled or cleared.
- R12: With the cycle counter disabled, no counter changes except through a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address while `bus_en_i` is high |
| event_i | input | N_EVT | One-cycle event strobes, indexed by event code |
| irq_o | output | 1 | Level interrupt on cycle counter overflow |

## Verification
The bench runs the cycle counter up to its top with a 0xF0 bias and checks the clock before and the clock after. A design that wraps instead of holding, or that freezes the event counters one clock late, shows a wrong count there. A second long run fills an event counter first. This catches a design that raises the interrupt for it or stops the cycle counter with it. Directed writes cover the two clear sequences, including a rewrite of a stored 1 to the cycle clear bit and a strobe that lands in the clear cycle. These expose edge-versus-level mix-ups and a dropped-strobe error. Random strobe patterns over random event codes, with codes 0 and above N_EVT mixed in, check the selection and the enable gating.

// File: rtl/perf_bank_pkg.sv
`timescale 1ns / 1ps
package perf_bank_pkg;
  // word offsets (byte offset / 4); the count window starts at 0x20
  localparam int unsigned WORD_VAL = 8;
  localparam logic [7:0] CODE_CYCLES = 8'h00;

  typedef struct packed {
    logic [7:0]  sel;
    logic [7:0]  par;
    logic [12:0] rsv;
    logic        en;
    logic        clr;
    logic        ovf;
  } ctrl_t;
endpackage

// File: rtl/perf_bank_decode.sv
`timescale 1ns / 1ps
module perf_bank_decode
  import perf_bank_pkg::*;
#(
  parameter int unsigned N_CNT = 4,
  parameter int unsigned CI_W  = 2
) (
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [7:0]       addr_i,
  output logic [N_CNT-1:0] ctrl_wr_o,
  output logic             rd_ctrl_o,
  output logic             rd_val_o,
  output logic [CI_W-1:0]  idx_o
);
  logic [5:0] word;
  logic       unused_w;

  assign word      = addr_i[7:2];
  assign unused_w  = ^addr_i[1:0];
  assign rd_ctrl_o = bus_en_i && (word < 6'(N_CNT));
  assign rd_val_o  = bus_en_i && (word >= 6'(WORD_VAL)) && (word < 6'(WORD_VAL + N_CNT));
  // both windows are 8-word aligned, so the low bits give the index
  assign idx_o     = word[CI_W-1:0];

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_wr
    assign ctrl_wr_o[gi] = rd_ctrl_o && bus_we_i && (idx_o == CI_W'(gi));
  end
endmodule

// File: rtl/perf_bank_counter.sv
`timescale 1ns / 1ps
module perf_bank_counter
  import perf_bank_pkg::*;
#(
  parameter bit          IS_CYCLE = 1'b0,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned N_EVT    = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  ctrl_t            wdata_i,
  input  logic             run_i,
  input  logic [N_EVT-1:0] evt_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PRE_LSB = CNT_W - 16;
  localparam int unsigned IDX_W   = $clog2(N_EVT);

  logic             en_q, clr_q, ovf_q;
  logic [7:0]       par_q, sel_q;
  logic [CNT_W-1:0] cnt_q, pre_w;
  logic             sel_hit, hit, step, clr_fire, at_max;
  logic             unused_w;

  assign unused_w = ^{wdata_i.ovf, wdata_i.rsv};
  assign sel_hit  = (sel_q != CODE_CYCLES) && (32'(sel_q) < N_EVT) && evt_i[sel_q[IDX_W-1:0]];
  assign hit      = IS_CYCLE ? 1'b1 : sel_hit;
  // cycle counter: clear on 0->1 of the bit; event counter: clear on a written 0
  assign clr_fire = wr_i && (IS_CYCLE ? (wdata_i.clr && !clr_q) : !wdata_i.clr);
  assign step     = run_i && en_q && !ovf_q && hit;
  assign at_max   = &cnt_q;

  always_comb begin
    pre_w = '0;
    pre_w[PRE_LSB +: 8] = wdata_i.par;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
      ovf_q <= 1'b0;
      par_q <= '0;
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) begin
        en_q  <= wdata_i.en;
        clr_q <= IS_CYCLE ? wdata_i.clr : 1'b1;
        par_q <= wdata_i.par;
        sel_q <= IS_CYCLE ? CODE_CYCLES : wdata_i.sel;
      end
      if (clr_fire) begin
        cnt_q <= pre_w;
        ovf_q <= 1'b0;
      end else if (step) begin
        if (at_max) ovf_q <= 1'b1;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_o     = '0;
    ctrl_o.sel = sel_q;
    ctrl_o.par = par_q;
    ctrl_o.en  = en_q;
    ctrl_o.clr = clr_q;
    ctrl_o.ovf = ovf_q;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/ddr_perf_bank.sv
`timescale 1ns / 1ps
module ddr_perf_bank
  import perf_bank_pkg::*;
#(
  parameter int unsigned N_CNT = 4,   // 2..8
  parameter int unsigned CNT_W = 32,  // 16..32
  parameter int unsigned N_EVT = 128  // 2..256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [N_EVT-1:0] event_i,
  output logic             irq_o
);
  localparam int unsigned CI_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;

  logic [N_CNT-1:0]            ctrl_wr;
  logic                        rd_ctrl, rd_val;
  logic [CI_W-1:0]             rd_idx;
  ctrl_t                       wdata_w;
  ctrl_t                       ctrl_w [N_CNT];
  logic [N_CNT-1:0][CNT_W-1:0] cnt_w;
  logic [N_CNT-1:0]            en_w, ovf_w;
  logic                        run_w;

  assign wdata_w = ctrl_t'(bus_wdata_i);

  perf_bank_decode #(.N_CNT(N_CNT), .CI_W(CI_W)) i_decode (
    .bus_en_i (bus_en_i),
    .bus_we_i (bus_we_i),
    .addr_i   (bus_addr_i),
    .ctrl_wr_o(ctrl_wr),
    .rd_ctrl_o(rd_ctrl),
    .rd_val_o (rd_val),
    .idx_o    (rd_idx)
  );

  // counter 0 is the cycle counter and gates the whole bank
  assign run_w = en_w[0] && !ovf_w[0];
  assign irq_o = ovf_w[0] && en_w[0];

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    perf_bank_counter #(
      .IS_CYCLE(gi == 0),
      .CNT_W   (CNT_W),
      .N_EVT   (N_EVT)
    ) i_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ctrl_wr[gi]),
      .wdata_i(wdata_w),
      .run_i  (run_w),
      .evt_i  (event_i),
      .ctrl_o (ctrl_w[gi]),
      .cnt_o  (cnt_w[gi])
    );
    assign en_w[gi]  = ctrl_w[gi].en;
    assign ovf_w[gi] = ctrl_w[gi].ovf;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_ctrl)     bus_rdata_o = ctrl_w[rd_idx];
    else if (rd_val) bus_rdata_o = 32'(cnt_w[rd_idx]);
  end
endmodule

// File: rtl/ddr_perf_bank_chk.sv
`timescale 1ns / 1ps
module ddr_perf_bank_chk #(
  parameter int unsigned N_CNT = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_any_i,
  input logic [N_CNT-1:0]            en_i,
  input logic [N_CNT-1:0]            ovf_i,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
  input logic                        irq_i
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R11
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ovf_i[0] && en_i[0]));

  // R12
  halt_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i[0] && !wr_any_i) |=> $stable(cnt_i));

  // R9
  freeze_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i[0] && !wr_any_i) |=> $stable(cnt_i));

  // R4
  cycle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[0] && !ovf_i[0] && !wr_any_i) |=> (ovf_i[0] || cnt_i[0] == $past(cnt_i[0]) + ONE));

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_chk
    // R7
    ovf_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ovf_i[gi]) |-> $past(wr_any_i));
    if (gi > 0) begin : g_evt
      // R10
      event_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_i[gi] && !wr_any_i) |=> $stable(cnt_i[gi]));
      // R10
      event_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_i[gi] && !ovf_i[0]) |-> !irq_i);
    end
  end
endmodule

bind ddr_perf_bank ddr_perf_bank_chk #(.N_CNT(N_CNT), .CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_any_i(bus_en_i && bus_we_i),
  .en_i    (en_w),
  .ovf_i   (ovf_w),
  .cnt_i   (cnt_w),
  .irq_i   (irq_o)
);

// File: tb/test_ddr_perf_bank.sv
`timescale 1ns / 1ps
module test_ddr_perf_bank;
  localparam int unsigned N_CNT = 4;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned N_EVT = 128;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bus_en_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0]       bus_addr_i = '0;
  logic [31:0]      bus_wdata_i = '0;
  logic [31:0]      bus_rdata_o;
  logic [N_EVT-1:0] event_i = '0;
  logic             irq_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;

  ddr_perf_bank #(.N_CNT(N_CNT), .CNT_W(CNT_W), .N_EVT(N_EVT)) i_ddr_perf_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .event_i(event_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] mk(input logic [7:0] sel, input logic [7:0] par,
                                     input logic en, input logic clr);
    return {sel, par, 13'd0, en, clr, 1'b0};
  endfunction

  function automatic logic [7:0] ca(input int i);
    return 8'(4 * i);
  endfunction

  function automatic logic [7:0] va(input int i);
    return 8'(8'h20 + 4 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called in the low clock phase; spans exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #0.01;
    d = bus_rdata_o;
    bus_en_i = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a0, b0;
    logic [7:0]  sel [N_CNT];
    int          exp_cnt [N_CNT];
    logic [7:0]  codes [8] = '{8'h04, 8'h05, 8'h08, 8'h09, 8'h20, 8'h21, 8'h41, 8'h42};
    void'($urandom(32'd1234));

    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1 reset state
    for (int i = 0; i < N_CNT; i++) begin
      rd(ca(i), d); chk("R1 ctrl", d, 32'h0);
      rd(va(i), d); chk("R1 count", d, 32'h0);
    end
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R3 field layout, read-only overflow bit, reserved bits
    wr(ca(1), mk(8'hAB, 8'h5A, 1'b0, 1'b1));
    rd(ca(1), d); chk("R3 ctrl1 fields", d, 32'hAB5A0002);
    wr(ca(1), 32'hAB5AFFFB);
    rd(ca(1), d); chk("R3 ovf and reserved ignored", d, 32'hAB5A0002);
    wr(ca(0), mk(8'h55, 8'h12, 1'b0, 1'b0));
    rd(ca(0), d); chk("R3 cycle code reads 0", d, 32'h00120000);
    // R2 map
    rd(8'h10, d); chk("R2 hole 0x10", d, 32'h0);
    rd(8'h40, d); chk("R2 hole 0x40", d, 32'h0);
    wr(va(1), 32'hFFFF_FFFF);
    rd(va(1), d); chk("R2 count write ignored", d, 32'h0);

    // R4 R5 R7 cycle counter clear and count
    wr(ca(0), mk(8'h00, 8'h10, 1'b1, 1'b1));
    rd(va(0), d); chk("R7 cycle preload", d, 32'h10);
    cyc(5);
    rd(va(0), d); chk("R4 cycle +5", d, 32'h15);
    wr(ca(0), mk(8'h00, 8'h33, 1'b1, 1'b1));
    rd(va(0), d); chk("R5 rewrite 1 no clear", d, 32'h16);
    wr(ca(0), mk(8'h00, 8'h33, 1'b1, 1'b0));
    rd(va(0), d); chk("R5 write 0 no clear", d, 32'h17);
    wr(ca(0), mk(8'h00, 8'h33, 1'b1, 1'b1));
    rd(va(0), d); chk("R5 rising clear", d, 32'h33);

    // R8 R6 R7 event counter
    wr(ca(2), mk(8'h04, 8'h00, 1'b1, 1'b1));
    rd(ca(2), d); chk("R6 ctrl2", d, 32'h04000006);
    event_i[4] = 1'b1; cyc(7); event_i = '0;
    rd(va(2), d); chk("R8 seven strobes", d, 32'h7);
    event_i[4] = 1'b1;
    wr(ca(2), mk(8'h04, 8'h22, 1'b1, 1'b0));
    event_i = '0;
    rd(va(2), d); chk("R7 clear drops strobe", d, 32'h22);
    rd(ca(2), d); chk("R6 clear reads back 1", d, 32'h04220006);

    // R8 code 0 and out-of-range codes count nothing
    wr(ca(3), mk(8'h00, 8'h00, 1'b1, 1'b0));
    event_i[0] = 1'b1; cyc(5); event_i = '0;
    rd(va(3), d); chk("R8 code 0", d, 32'h0);
    wr(ca(3), mk(8'hC0, 8'h00, 1'b1, 1'b1));
    event_i = '1; cyc(5); event_i = '0;
    rd(va(3), d); chk("R8 code above range", d, 32'h0);
    rd(va(1), d); chk("R8 disabled counter", d, 32'h0);
    rd(va(2), d); chk("R8 enabled counter", d, 32'h27);

    // R12 cycle counter disabled halts everything
    wr(ca(0), mk(8'h00, 8'h33, 1'b0, 1'b0));
    rd(va(0), a0); rd(va(2), b0);
    event_i[4] = 1'b1; cyc(5); event_i = '0;
    rd(va(0), d); chk("R12 cycle held", d, a0);
    rd(va(2), d); chk("R12 event held", d, b0);

    // R8 R4 random strobes over random codes
    wr(ca(0), mk(8'h00, 8'h00, 1'b1, 1'b1));
    for (int r = 0; r < 3; r++) begin
      for (int i = 1; i < N_CNT; i++) begin
        sel[i] = ($urandom % 4 == 0) ? codes[$urandom % 8] : 8'($urandom % 256);
        exp_cnt[i] = 0;
        wr(ca(i), mk(sel[i], 8'h00, 1'b1, 1'b0));
      end
      rd(va(0), a0);
      for (int n = 0; n < 300; n++) begin
        event_i = {$urandom, $urandom, $urandom, $urandom};
        for (int i = 1; i < N_CNT; i++)
          if (sel[i] != 8'h00 && 32'(sel[i]) < N_EVT && event_i[sel[i][6:0]]) exp_cnt[i]++;
        @(negedge clk_i);
      end
      event_i = '0;
      for (int i = 1; i < N_CNT; i++) begin
        rd(va(i), d); chk($sformatf("R8 random code 0x%02h", sel[i]), d, 32'(exp_cnt[i]));
      end
      rd(va(0), d); chk("R4 cycle over random run", d - a0, 32'd300);
    end

    // R9 biased cycle counter overflow freezes the bank
    wr(ca(0), mk(8'h00, 8'h00, 1'b0, 1'b0));
    wr(ca(1), mk(8'h04, 8'h00, 1'b1, 1'b0));
    event_i[4] = 1'b1;
    wr(ca(0), mk(8'h00, 8'hF0, 1'b1, 1'b1));
    cyc(65295);
    rd(va(0), d); chk("R9 cycle at top", d, 32'hFFFF);
    rd(va(1), d); chk("R9 event before freeze", d, 32'hFF0F);
    chk("R11 irq low before overflow", 32'(irq_o), 32'h0);
    cyc(1);
    chk("R11 irq on overflow", 32'(irq_o), 32'h1);
    rd(ca(0), d); chk("R9 cycle ovf flag", d, 32'h00F00007);
    rd(va(0), d); chk("R9 cycle holds top", d, 32'hFFFF);
    rd(va(1), d); chk("R9 event last step", d, 32'hFF10);
    cyc(20);
    rd(va(0), d); chk("R9 cycle frozen", d, 32'hFFFF);
    rd(va(1), d); chk("R9 event frozen", d, 32'hFF10);

    // R11 interrupt release
    wr(ca(0), mk(8'h00, 8'hF0, 1'b0, 1'b1));
    chk("R11 irq off on disable", 32'(irq_o), 32'h0);
    rd(ca(0), d); chk("R11 flag kept, no clear", d, 32'h00F00003);
    wr(ca(0), mk(8'h00, 8'h00, 1'b0, 1'b0));
    wr(ca(0), mk(8'h00, 8'h00, 1'b1, 1'b1));
    rd(ca(0), d); chk("R7 clear drops cycle ovf", d, 32'h00000006);
    chk("R11 irq off after clear", 32'(irq_o), 32'h0);
    cyc(3);
    rd(va(0), d); chk("R4 cycle restarted", d, 32'h3);
    rd(va(1), d); chk("R9 event resumes", d, 32'hFF13);

    // R10 event counter overflow stops only itself
    event_i = '0;
    wr(ca(0), mk(8'h00, 8'h00, 1'b0, 1'b0));
    wr(ca(2), mk(8'h05, 8'hFF, 1'b1, 1'b0));
    event_i[5] = 1'b1;
    wr(ca(0), mk(8'h00, 8'h00, 1'b1, 1'b1));
    cyc(65280);
    rd(va(2), d); chk("R10 event at top", d, 32'hFFFF);
    rd(ca(2), d); chk("R10 no flag yet", d, 32'h05FF0006);
    cyc(1);
    rd(ca(2), d); chk("R10 event ovf flag", d, 32'h05FF0007);
    rd(va(2), d); chk("R10 event holds top", d, 32'hFFFF);
    chk("R10 no irq", 32'(irq_o), 32'h0);
    rd(va(0), d); chk("R10 cycle value", d, 32'hFF01);
    cyc(5);
    rd(va(2), d); chk("R10 event stopped", d, 32'hFFFF);
    rd(va(0), d); chk("R10 cycle goes on", d, 32'hFF06);
    wr(ca(2), mk(8'h05, 8'h00, 1'b1, 1'b0));
    rd(va(2), d); chk("R7 event clear with strobe", d, 32'h0);
    rd(ca(2), d); chk("R7 event ovf dropped", d, 32'h05000006);
    event_i = '0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule